// File: doc/BRIEF.md
# Double-Buffered Profile Register Bank

The block stores eight tuning profiles for a direct digital synthesis core. Each profile holds a 32-bit frequency word and a 16-bit phase offset. Host writes never reach the values that the core uses directly. They land in a buffer copy of the profile. A transfer event copies the whole buffer bank into the active bank in one cycle. The core then reads the active frequency and phase of the currently selected profile.

Three active-high select pins choose the profile. These pins are asynchronous to the block clock, so they pass through a two-stage synchronizer. When the synchronized code differs from its previous value, the block raises a transfer. That transfer copies every pending buffered write and also adopts the new profile index. A single-cycle update strobe triggers the same copy without a change of profile. This lets the host commit new values to the profile that is already selected.

Top module: `profile_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, every buffer and active register is cleared and the selected index becomes 0, so `act_freq`, `act_phase` and `act_prof` read zero.
- R2: A write (`wr_en` high at a rising edge) updates only the buffer copy of profile `wr_prof`, with field code 0 for the frequency and code 1 for the phase. The outputs do not change until a later transfer.
- R3: Suppose `sel_pins` take a new value before rising edge k and hold it. The outputs are unchanged after edges k and k+1. After edge k+2 they show the active values of the new profile, and `act_prof` equals the new code. This holds for every pair of distinct codes.
- R4: A transfer copies the buffers of all eight profiles, not only the selected one. A profile written before a transfer therefore shows its written values when it is selected later.
- R5: `upd_strobe` high at a rising edge performs a transfer at that edge and leaves the selected profile unchanged.
- R6: A write and a transfer at the same edge give the active bank the buffer contents from before that write. The new value stays pending until the next transfer.
- R7: A phase write keeps bits 15:0 of `wr_data` and ignores the upper bits. Writing one field of a profile leaves its other field untouched.
- R8: When the select pins are steady and `upd_strobe` is low, the active bank and the outputs stay constant, even while writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write enable |
| wr_prof | input | 3 | Profile index of the write |
| wr_field | input | 1 | Field code: 0 frequency, 1 phase |
| wr_data | input | 32 | Write data; phase takes bits 15:0 |
| upd_strobe | input | 1 | Commit buffers to active bank without a profile change |
| sel_pins | input | 3 | Asynchronous active-high profile select |
| act_freq | output | 32 | Active frequency word of the selected profile |
| act_phase | output | 16 | Active phase offset of the selected profile |
| act_prof | output | 3 | Index of the profile now presented |

## Verification
The bench visits every ordered pair of distinct select codes and samples at each of the three edges after a pin change. A design with one synchronizer stage too few or too many therefore shows the new profile a cycle early or late. Before each move, the bench writes to the target profile and to a neighbour. A bank that copied only the selected profile would then show stale neighbour data later on. Writes that arrive on the same edge as a strobe, over-wide phase data and idle cycles with writes expose three further faults: a design that forwards write data straight to the active bank, one that keeps phase bits above 15, and one that transfers without an event.

// File: rtl/prof_bank_pkg.sv
// Package: shared field encoding for the profile register bank.
// Assumes: the write port carries a single field-select bit.
package prof_bank_pkg;

    // Which half of a profile a host write targets.
    typedef enum logic {
        FLD_FREQ  = 1'b0,
        FLD_PHASE = 1'b1
    } prof_field_e;

endpackage

// File: rtl/prof_sel_sync.sv
// Module: prof_sel_sync
// Brings the asynchronous profile-select pins into the clock domain through
// two flops. A third flop holds the previous synchronized code, and a
// difference between the two flags a change for exactly one cycle per
// settled transition.
// Assumes: pins are held long enough to be captured (at least two cycles).
module prof_sel_sync #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_async,
    output logic [SEL_W-1:0] sel_sync,
    output logic             sel_change
);

    logic [SEL_W-1:0] meta_q;
    logic [SEL_W-1:0] sync_q;
    logic [SEL_W-1:0] prev_q;

    // Purpose: two-stage synchronizer plus history flop for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= sel_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: expose the settled code and the one-cycle change flag.
    always_comb begin
        sel_sync   = sync_q;
        sel_change = (sync_q != prev_q);
    end

    // R3: a change flag cannot repeat on the next cycle without a new pin value.
    p_change_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change && $stable(meta_q) |=> !sel_change);

endmodule

// File: rtl/prof_buffer_bank.sv
// Module: prof_buffer_bank
// Holds the host-visible buffer copy of every profile. A write touches one
// field of one profile. Phase writes keep only the low PHASE_W bits.
// Assumes: NPROF is a power of two so every wr_prof code names a profile.
module prof_buffer_bank
    import prof_bank_pkg::*;
#(
    parameter int NPROF   = 8,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16,
    parameter int SEL_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_prof,
    input  logic                            wr_field,
    input  logic [FREQ_W-1:0]               wr_data,
    output logic [NPROF-1:0][FREQ_W-1:0]    buf_freq,
    output logic [NPROF-1:0][PHASE_W-1:0]   buf_phase
);

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        logic hit;

        // Purpose: decode whether this write targets profile p.
        always_comb begin
            hit = wr_en && (wr_prof == SEL_W'(p));
        end

        // Purpose: buffer frequency word of profile p.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_freq[p] <= '0;
            end else if (hit && (wr_field == FLD_FREQ)) begin
                buf_freq[p] <= wr_data;
            end
        end

        // Purpose: buffer phase offset of profile p, truncated to PHASE_W.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_phase[p] <= '0;
            end else if (hit && (wr_field == FLD_PHASE)) begin
                buf_phase[p] <= wr_data[PHASE_W-1:0];
            end
        end
    end

    // R2: a frequency write lands in the addressed buffer.
    p_wr_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_field == FLD_FREQ) |=> buf_freq[$past(wr_prof)] == $past(wr_data));

    // R7: a phase write keeps the low bits and leaves the frequency alone.
    p_wr_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_field == FLD_PHASE) |=>
            buf_phase[$past(wr_prof)] == $past(wr_data[PHASE_W-1:0]) &&
            $stable(buf_freq));

endmodule

// File: rtl/prof_active_bank.sv
// Module: prof_active_bank
// The active copy of all profiles. On a transfer pulse, every profile is
// loaded from the buffer bank in the same cycle. Otherwise it holds.
// Assumes: the transfer pulse is already in the clock domain.
module prof_active_bank #(
    parameter int NPROF   = 8,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            xfer,
    input  logic [NPROF-1:0][FREQ_W-1:0]    buf_freq,
    input  logic [NPROF-1:0][PHASE_W-1:0]   buf_phase,
    output logic [NPROF-1:0][FREQ_W-1:0]    act_freq,
    output logic [NPROF-1:0][PHASE_W-1:0]   act_phase
);

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        // Purpose: load profile p from its buffer on a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_freq[p]  <= '0;
                act_phase[p] <= '0;
            end else if (xfer) begin
                act_freq[p]  <= buf_freq[p];
                act_phase[p] <= buf_phase[p];
            end
        end
    end

    // R4: a transfer captures the whole buffer bank.
    p_copy_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> act_freq == $past(buf_freq) && act_phase == $past(buf_phase));

    // R8: without a transfer the active bank holds.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(act_freq) && $stable(act_phase));

endmodule

// File: rtl/prof_out_select.sv
// Module: prof_out_select
// Registers the presented profile index on each transfer and steers the
// matching active entry to the outputs.
// Assumes: sel_sync is the settled select code in the clock domain.
module prof_out_select #(
    parameter int NPROF   = 8,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16,
    parameter int SEL_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            xfer,
    input  logic [SEL_W-1:0]                sel_sync,
    input  logic [NPROF-1:0][FREQ_W-1:0]    act_freq,
    input  logic [NPROF-1:0][PHASE_W-1:0]   act_phase,
    output logic [SEL_W-1:0]                cur_idx,
    output logic [FREQ_W-1:0]               out_freq,
    output logic [PHASE_W-1:0]              out_phase
);

    // Purpose: adopt the settled select code on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
        end else if (xfer) begin
            cur_idx <= sel_sync;
        end
    end

    // Purpose: steer the chosen active profile to the outputs.
    always_comb begin
        out_freq  = act_freq[cur_idx];
        out_phase = act_phase[cur_idx];
    end

    // R3: the index tracks the settled select code after a transfer.
    p_idx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> cur_idx == $past(sel_sync));

    // R8: the index holds between transfers.
    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(cur_idx));

endmodule

// File: rtl/profile_bank.sv
// Module: profile_bank (top)
// Eight-entry double-buffered frequency/phase profile store. Host writes go
// to buffers. A select-pin change or an update strobe commits all buffers
// to the active bank, and the selected active entry drives the outputs.
// Assumes: clk is the sync clock of the synthesis core; reset is synchronous.
module profile_bank #(
    parameter int NPROF   = 8,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NPROF)-1:0]   wr_prof,
    input  logic                       wr_field,
    input  logic [FREQ_W-1:0]          wr_data,
    input  logic                       upd_strobe,
    input  logic [$clog2(NPROF)-1:0]   sel_pins,
    output logic [FREQ_W-1:0]          act_freq,
    output logic [PHASE_W-1:0]         act_phase,
    output logic [$clog2(NPROF)-1:0]   act_prof
);

    localparam int SEL_W = $clog2(NPROF);

    logic [SEL_W-1:0]                 sel_sync;
    logic                             sel_change;
    logic                             xfer;
    logic [NPROF-1:0][FREQ_W-1:0]     buf_freq;
    logic [NPROF-1:0][PHASE_W-1:0]    buf_phase;
    logic [NPROF-1:0][FREQ_W-1:0]     bank_freq;
    logic [NPROF-1:0][PHASE_W-1:0]    bank_phase;

    prof_sel_sync #(.SEL_W(SEL_W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_async  (sel_pins),
        .sel_sync   (sel_sync),
        .sel_change (sel_change)
    );

    // Purpose: merge the two transfer sources.
    always_comb begin
        xfer = sel_change | upd_strobe;
    end

    prof_buffer_bank #(
        .NPROF(NPROF), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .SEL_W(SEL_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_prof   (wr_prof),
        .wr_field  (wr_field),
        .wr_data   (wr_data),
        .buf_freq  (buf_freq),
        .buf_phase (buf_phase)
    );

    prof_active_bank #(
        .NPROF(NPROF), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .buf_freq  (buf_freq),
        .buf_phase (buf_phase),
        .act_freq  (bank_freq),
        .act_phase (bank_phase)
    );

    prof_out_select #(
        .NPROF(NPROF), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .SEL_W(SEL_W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .sel_sync  (sel_sync),
        .act_freq  (bank_freq),
        .act_phase (bank_phase),
        .cur_idx   (act_prof),
        .out_freq  (act_freq),
        .out_phase (act_phase)
    );

    // R1: reset clears the presented profile.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> act_freq == '0 && act_phase == '0 && act_prof == '0);

    // R5: a strobe with steady pins commits buffers but keeps the index.
    p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe && !sel_change |=> act_prof == $past(act_prof) &&
            bank_freq == $past(buf_freq));

    // R6: a write on a transfer edge is not seen by the active bank.
    p_wr_on_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && wr_en |=> bank_phase == $past(buf_phase));

endmodule

// File: tb/profile_bank_tb.sv
module profile_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_prof = '0;
    logic        wr_field = 1'b0;
    logic [31:0] wr_data = '0;
    logic        upd_strobe = 1'b0;
    logic [2:0]  sel_pins = '0;
    logic [31:0] act_freq;
    logic [15:0] act_phase;
    logic [2:0]  act_prof;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model: buffer and active copies, presented index, pin value.
    logic [31:0] mb_f [8];
    logic [15:0] mb_p [8];
    logic [31:0] ma_f [8];
    logic [15:0] ma_p [8];
    int          m_idx = 0;
    logic [2:0]  m_pins = '0;

    always #2.5 clk = ~clk;

    profile_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_prof(wr_prof),
        .wr_field(wr_field), .wr_data(wr_data), .upd_strobe(upd_strobe),
        .sel_pins(sel_pins), .act_freq(act_freq), .act_phase(act_phase),
        .act_prof(act_prof)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag);
        n_chk++;
        if (act_freq !== ma_f[m_idx] || act_phase !== ma_p[m_idx] ||
            act_prof !== 3'(m_idx)) begin
            n_fail++;
            $display("FAIL %s: got freq=%h phase=%h prof=%0d exp freq=%h phase=%h prof=%0d",
                     tag, act_freq, act_phase, act_prof,
                     ma_f[m_idx], ma_p[m_idx], m_idx);
        end
    endtask

    task automatic commit_model();
        for (int i = 0; i < 8; i++) begin
            ma_f[i] = mb_f[i];
            ma_p[i] = mb_p[i];
        end
    endtask

    task automatic model_write(input int p, input bit fld, input logic [31:0] d);
        if (fld) mb_p[p] = d[15:0];
        else     mb_f[p] = d;
    endtask

    task automatic do_write(input int p, input bit fld, input logic [31:0] d);
        wr_en = 1'b1; wr_prof = 3'(p); wr_field = fld; wr_data = d;
        tick();
        wr_en = 1'b0;
        model_write(p, fld, d);
    endtask

    task automatic do_strobe();
        upd_strobe = 1'b1;
        tick();
        upd_strobe = 1'b0;
        commit_model();
    endtask

    // Pin change: old after edges k and k+1, new after edge k+2.
    task automatic move_sel(input int v);
        if (3'(v) != m_pins) begin
            sel_pins = 3'(v);
            tick(); chk("R3 edge k");
            tick(); chk("R3 edge k+1");
            tick();
            commit_model();
            m_idx = v; m_pins = 3'(v);
            chk("R3 edge k+2");
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            mb_f[i] = '0; mb_p[i] = '0; ma_f[i] = '0; ma_p[i] = '0;
        end
        repeat (3) tick();
        chk("R1 during reset");
        rst_n = 1'b1;
        tick();
        chk("R1 after reset");

        // R2 / R8: writes alone never move the outputs.
        do_write(0, 1'b0, 32'hCAFE_0001);
        chk("R2 freq write pending");
        do_write(0, 1'b1, 32'h0000_5A5A);
        chk("R2 phase write pending");
        for (int i = 0; i < 4; i++) begin
            do_write(i + 1, i[0], 32'h1111_0000 + 32'(i));
            chk("R8 idle with writes");
        end

        // R5: strobe commits without changing the index.
        do_strobe();
        chk("R5 strobe commit");

        // R7: over-wide phase data and untouched frequency field.
        do_write(0, 1'b1, 32'hABCD_1234);
        do_strobe();
        chk("R7 phase truncation");
        if (act_phase !== 16'h1234 || act_freq !== 32'hCAFE_0001) begin
            n_fail++;
            $display("FAIL R7: got phase=%h freq=%h exp phase=1234 freq=cafe0001",
                     act_phase, act_freq);
        end
        n_chk++;

        // R6: write on the strobe edge stays pending.
        do_write(0, 1'b0, 32'h0BAD_0000);
        do_strobe();
        chk("R6 baseline");
        wr_en = 1'b1; wr_prof = 3'd0; wr_field = 1'b0; wr_data = 32'h600D_0000;
        upd_strobe = 1'b1;
        tick();
        wr_en = 1'b0; upd_strobe = 1'b0;
        commit_model();
        model_write(0, 1'b0, 32'h600D_0000);
        chk("R6 write on transfer edge not visible");
        do_strobe();
        chk("R6 pending write committed later");

        // R3 / R4: every ordered pair of distinct codes.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a != b) begin
                    move_sel(a);
                    do_write(b, 1'b0, 32'h9E37_79B9 * 32'(a * 8 + b + 1));
                    do_write(b, 1'b1, 32'(a * 4099 + b * 257 + 7));
                    do_write((b + 1) % 8, 1'b0, 32'h0F0F_0000 ^ 32'(a * 16 + b));
                    chk("R8 writes before move");
                    move_sel(b);
                    chk("R4 target shows written data");
                end
            end
        end

        // R4: neighbour written earlier appears when selected afterwards.
        do_write(5, 1'b0, 32'h5555_AAAA);
        move_sel((m_idx + 1) % 8 == 5 ? 6 : (m_idx + 1) % 8);
        move_sel(5);
        chk("R4 neighbour copy");

        // R1: reset mid-run clears everything.
        rst_n = 1'b0;
        tick();
        for (int i = 0; i < 8; i++) begin
            mb_f[i] = '0; mb_p[i] = '0; ma_f[i] = '0; ma_p[i] = '0;
        end
        m_idx = 0;
        chk("R1 reset mid-run");
        sel_pins = '0; m_pins = '0;
        rst_n = 1'b1;
        tick();
        chk("R1 after second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule